// File: doc/BRIEF.md
# FPGA Configuration and Reset Sequencer

This block runs inside a small programmable device next to an FPGA. It loads a bitstream into the FPGA through a byte-wide slave parallel configuration port. A static switch input chooses where the bitstream comes from:

- **Link mode:** a byte-wide handshaked link port supplies the bytes.
- **Flash mode:** the bitstream is read from a parallel flash of 16-bit words.

The block first clears the FPGA with an active-low program pulse and waits for the FPGA's init-ready signal. It then writes one byte per clock into the configuration port. The configuration bus is sampled on the block clock.

While this runs, the design-level reset of the FPGA is held low. The reset is released only after a fixed 32-bit end key has passed through the byte stream and the FPGA reports done. At that point the shared link port is also handed over to the FPGA.

Because the end key releases the reset, an FPGA that was loaded by another path can still be brought out of reset. In link mode, sending the key over the link is enough. A power-up reset or a low level on the global system reset input restarts the whole sequence.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, or the global reset `sys_rst_n_i` has been seen low through a two-flop synchronizer, the sequence restarts: `design_rst_n_o`=0, `cfg_prog_n_o`=0, `lnk_own_o`=1, `err_o`=0.
- R2: After reset, `cfg_prog_n_o` stays low for at least PROG_CYC (4) clocks. No byte is accepted or written until `cfg_init_i` is high.
- R3: With `src_flash_i`=0, the link supplies the bitstream. A byte is taken in a cycle where `lnk_ready_o` and `lnk_valid_i` are both 1. One cycle later it appears on `cfg_data_o`, with `cfg_cs_n_o` and `cfg_wr_n_o` both low for that one cycle.
- R4: With `src_flash_i`=1, words are read from `fl_addr_o`, which starts at 0 and increments by 1. `fl_oe_n_o` is low and the address is held for FL_WAIT (4) clocks per word. The word's low byte (bits 7:0) is written first, then the high byte.
- R5: The end key is 0xE0DE0E0D, taken from four consecutive stream bytes, least significant byte first (0x0D, 0x0E, 0xDE, 0xE0). A mismatching byte restarts the match, and that byte counts as a first key byte if it equals 0x0D.
- R6: `design_rst_n_o` rises only after the last key byte, and only once `cfg_done_i` is high. With `cfg_done_i` already high, it rises two clocks after the key byte is taken. In flash mode, the release follows the key read out of the flash.
- R7: `lnk_own_o` is 1 while `design_rst_n_o` is 0 and drops to 0 on release. `lnk_ready_o` is 0 whenever the block does not own the link. Link bytes offered then are not written.
- R8: If `cfg_done_i` stays low for 2^TO_W clocks after the key, `err_o` goes to 1 and the design reset stays low. Only a new reset (R1) clears the error.
- R9: In link mode, the four key bytes sent alone, with DONE already high, release the design reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also paces the configuration bus |
| rst_n | input | 1 | Power-up reset, asynchronous, active low |
| sys_rst_n_i | input | 1 | Global system reset, asynchronous, active low |
| src_flash_i | input | 1 | Static source switch: 1 = flash, 0 = link |
| lnk_data_i | input | 8 | Link byte |
| lnk_valid_i | input | 1 | Link byte present |
| lnk_ready_o | output | 1 | Block takes a link byte this cycle |
| lnk_own_o | output | 1 | 1 = block owns the link, 0 = FPGA owns it |
| cfg_prog_n_o | output | 1 | FPGA program pulse, active low |
| cfg_init_i | input | 1 | FPGA ready for configuration data |
| cfg_done_i | input | 1 | FPGA configuration done |
| cfg_cs_n_o | output | 1 | Configuration chip select, active low |
| cfg_wr_n_o | output | 1 | Configuration write enable, active low |
| cfg_data_o | output | 8 | Configuration data byte |
| fl_addr_o | output | 24 | Flash word address |
| fl_oe_n_o | output | 1 | Flash output enable, active low |
| fl_data_i | input | 16 | Flash read word |
| design_rst_n_o | output | 1 | FPGA design reset, active low |
| err_o | output | 1 | DONE timeout error |

## Verification
A wrong key-match index shows up as early or missing reset release within two clocks of the byte that should have completed the key. The restart-on-mismatch table targets exactly that case. A corrupted byte path or flash byte order shows on `cfg_data_o` one cycle after the byte is taken. A stuck sequencer state shows as `lnk_ready_o` low when a byte is due, or as the link owner and the design reset disagreeing in the same cycle. A faulty timeout counter shows as `err_o` rising too early or not at all within the 2^TO_W-cycle window.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int KEY_W  = 32;
  localparam int KEY_N  = KEY_W / BYTE_W;
  localparam logic [KEY_W-1:0] END_KEY = 32'hE0DE_0E0D;

  typedef enum logic [3:0] {
    S_PROG, S_WINIT, S_LINK, S_FRD, S_FLO, S_FHI, S_DWAIT, S_RUN, S_ERR
  } seq_st_e;
endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n_i,
  output logic sync_n_o
);
  logic ff1_q, ff2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff1_q <= 1'b0;
      ff2_q <= 1'b0;
    end else begin
      ff1_q <= async_n_i;
      ff2_q <= ff1_q;
    end
  end
  assign sync_n_o = ff2_q;
endmodule

// File: rtl/cfg_key_match.sv
module cfg_key_match
  import cfg_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              stb_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              hit_o
);
  localparam int IDX_W = $clog2(KEY_N);
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [BYTE_W-1:0] exp_byte;
  logic [BYTE_W-1:0] key_bytes [KEY_N];

  for (genvar g = 0; g < KEY_N; g++) begin : g_kb
    assign key_bytes[g] = END_KEY[g*BYTE_W +: BYTE_W];
  end

  assign exp_byte = key_bytes[idx_q];
  assign hit_o    = stb_i && (byte_i == exp_byte) && (idx_q == IDX_W'(KEY_N-1));

  always_comb begin
    idx_d = idx_q;
    if (clr_i) begin
      idx_d = '0;
    end else if (stb_i) begin
      if (byte_i == exp_byte)
        idx_d = hit_o ? '0 : idx_q + 1'b1;
      else
        idx_d = (byte_i == key_bytes[0]) ? IDX_W'(1) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end
endmodule

// File: rtl/cfg_port_wr.sv
module cfg_port_wr
  import cfg_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              cs_n_o,
  output logic              wr_n_o,
  output logic [BYTE_W-1:0] data_o
);
  logic              vld_q;
  logic [BYTE_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= stb_i;
      if (stb_i) data_q <= byte_i;
    end
  end

  assign cs_n_o = !vld_q;
  assign wr_n_o = !vld_q;
  assign data_o = data_q;
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int FL_AW    = 24,
  parameter int PROG_CYC = 4,
  parameter int FL_WAIT  = 4,
  parameter int TO_W     = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_rst_n_i,
  input  logic              src_flash_i,
  input  logic [7:0]        lnk_data_i,
  input  logic              lnk_valid_i,
  output logic              lnk_ready_o,
  output logic              lnk_own_o,
  output logic              cfg_prog_n_o,
  input  logic              cfg_init_i,
  input  logic              cfg_done_i,
  output logic              cfg_cs_n_o,
  output logic              cfg_wr_n_o,
  output logic [7:0]        cfg_data_o,
  output logic [FL_AW-1:0]  fl_addr_o,
  output logic              fl_oe_n_o,
  input  logic [15:0]       fl_data_i,
  output logic              design_rst_n_o,
  output logic              err_o
);
  localparam int FL_DW = 2 * BYTE_W;
  localparam int CNT_W = TO_W;
  localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(FL_WAIT - 1);
  localparam logic [CNT_W-1:0] TO_LAST   = '1;

  seq_st_e           state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [FL_AW-1:0]  addr_q, addr_d;
  logic [FL_DW-1:0]  word_q, word_d;
  logic              sys_ok;
  logic              byte_stb;
  logic [BYTE_W-1:0] byte_val;
  logic              key_hit;

  cfg_rst_sync u_sync (
    .clk(clk), .rst_n(rst_n), .async_n_i(sys_rst_n_i), .sync_n_o(sys_ok)
  );

  // byte source mux: link byte or one half of the fetched flash word
  always_comb begin
    byte_stb = 1'b0;
    byte_val = lnk_data_i;
    if (sys_ok) begin
      case (state_q)
        S_LINK: byte_stb = lnk_valid_i;
        S_FLO: begin byte_stb = 1'b1; byte_val = word_q[BYTE_W-1:0]; end
        S_FHI: begin byte_stb = 1'b1; byte_val = word_q[FL_DW-1:BYTE_W]; end
        default: byte_stb = 1'b0;
      endcase
    end
  end

  cfg_key_match u_key (
    .clk(clk), .rst_n(rst_n), .clr_i(state_q == S_PROG),
    .stb_i(byte_stb), .byte_i(byte_val), .hit_o(key_hit)
  );

  cfg_port_wr u_wr (
    .clk(clk), .rst_n(rst_n), .stb_i(byte_stb), .byte_i(byte_val),
    .cs_n_o(cfg_cs_n_o), .wr_n_o(cfg_wr_n_o), .data_o(cfg_data_o)
  );

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    addr_d  = addr_q;
    word_d  = word_q;
    case (state_q)
      S_PROG:
        if (cnt_q == PROG_LAST) begin state_d = S_WINIT; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      S_WINIT:
        if (cfg_init_i) begin
          state_d = src_flash_i ? S_FRD : S_LINK;
          cnt_d   = '0;
          addr_d  = '0;
        end
      S_LINK:
        if (key_hit) begin state_d = S_DWAIT; cnt_d = '0; end
      S_FRD:
        if (cnt_q == WAIT_LAST) begin
          word_d  = fl_data_i;
          state_d = S_FLO;
          cnt_d   = '0;
        end else cnt_d = cnt_q + 1'b1;
      S_FLO:
        if (key_hit) begin state_d = S_DWAIT; cnt_d = '0; end
        else state_d = S_FHI;
      S_FHI: begin
        addr_d = addr_q + 1'b1;
        if (key_hit) begin state_d = S_DWAIT; cnt_d = '0; end
        else state_d = S_FRD;
      end
      S_DWAIT:
        if (cfg_done_i)             state_d = S_RUN;
        else if (cnt_q == TO_LAST)  state_d = S_ERR;
        else                        cnt_d = cnt_q + 1'b1;
      default: state_d = state_q;
    endcase
    if (!sys_ok) begin
      state_d = S_PROG;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_PROG;
      cnt_q   <= '0;
      addr_q  <= '0;
      word_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      addr_q  <= addr_d;
      word_q  <= word_d;
    end
  end

  assign lnk_ready_o    = (state_q == S_LINK) && sys_ok;
  assign lnk_own_o      = (state_q != S_RUN);
  assign design_rst_n_o = (state_q == S_RUN);
  assign cfg_prog_n_o   = (state_q != S_PROG);
  assign fl_oe_n_o      = (state_q != S_FRD);
  assign fl_addr_o      = addr_q;
  assign err_o          = (state_q == S_ERR);
endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk #(
  parameter int FL_AW = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lnk_ready_o,
  input logic             lnk_own_o,
  input logic             cfg_prog_n_o,
  input logic             cfg_done_i,
  input logic             cfg_cs_n_o,
  input logic             cfg_wr_n_o,
  input logic [FL_AW-1:0] fl_addr_o,
  input logic             fl_oe_n_o,
  input logic             design_rst_n_o,
  input logic             err_o
);
  p_own_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    design_rst_n_o |-> !lnk_own_o);
  p_ready_owned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_ready_o |-> (lnk_own_o && !design_rst_n_o));
  p_prog_holds_rst_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_prog_n_o |-> !design_rst_n_o);
  p_wr_framed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_n_o |-> (!cfg_cs_n_o && cfg_prog_n_o));
  p_release_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(design_rst_n_o) |-> $past(cfg_done_i));
  p_err_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !design_rst_n_o);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> (err_o || !cfg_prog_n_o));
  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_oe_n_o && $past(!fl_oe_n_o)) |-> $stable(fl_addr_o));
endmodule

bind cfg_seq_ctrl cfg_seq_chk #(.FL_AW(FL_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lnk_ready_o(lnk_ready_o), .lnk_own_o(lnk_own_o),
  .cfg_prog_n_o(cfg_prog_n_o), .cfg_done_i(cfg_done_i), .cfg_cs_n_o(cfg_cs_n_o),
  .cfg_wr_n_o(cfg_wr_n_o), .fl_addr_o(fl_addr_o), .fl_oe_n_o(fl_oe_n_o),
  .design_rst_n_o(design_rst_n_o), .err_o(err_o)
);

// File: tb/cfg_seq_ctrl_tb_top.sv
module cfg_seq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, sys_rst_n, src_flash, lnk_valid, init, done;
  logic [7:0]  lnk_data;
  logic        lnk_ready, lnk_own, prog_n, cs_n, wr_n, fl_oe_n, drst_n, err;
  logic [7:0]  cfg_data;
  logic [23:0] fl_addr;
  logic [15:0] fl_data;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  cfg_seq_ctrl #(.TO_W(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .sys_rst_n_i(sys_rst_n), .src_flash_i(src_flash),
    .lnk_data_i(lnk_data), .lnk_valid_i(lnk_valid), .lnk_ready_o(lnk_ready),
    .lnk_own_o(lnk_own), .cfg_prog_n_o(prog_n), .cfg_init_i(init), .cfg_done_i(done),
    .cfg_cs_n_o(cs_n), .cfg_wr_n_o(wr_n), .cfg_data_o(cfg_data),
    .fl_addr_o(fl_addr), .fl_oe_n_o(fl_oe_n), .fl_data_i(fl_data),
    .design_rst_n_o(drst_n), .err_o(err)
  );

  // flash model: words 0..2 hold 0x1234 then the key halves
  always_comb begin
    case (fl_addr)
      24'd0:   fl_data = 16'h1234;
      24'd1:   fl_data = 16'h0E0D;
      24'd2:   fl_data = 16'hE0DE;
      default: fl_data = 16'hFFFF;
    endcase
  end

  // byte / address monitor
  logic [7:0] cap [16];
  int ncap = 0, max_addr = 0, oe_run = 0, min_oe_run = 1000;
  always @(negedge clk) begin
    if (!wr_n && !cs_n && ncap < 16) begin cap[ncap] = cfg_data; ncap++; end
    if (!fl_oe_n) begin
      oe_run++;
      if (int'(fl_addr) > max_addr) max_addr = int'(fl_addr);
    end else if (oe_run != 0) begin
      if (oe_run < min_oe_run) min_oe_run = oe_run;
      oe_run = 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic rel, input string tg);
    @(negedge clk); lnk_valid = 1'b1; lnk_data = b;
    @(negedge clk); lnk_valid = 1'b0;
    check({tg, " R3 wr strobe"}, {31'd0, wr_n}, 32'd0);
    check({tg, " R3 data"}, {24'd0, cfg_data}, {24'd0, b});
    @(negedge clk);
    check({tg, " R6 reset"}, {31'd0, drst_n}, {31'd0, rel});
    check({tg, " R7 owner"}, {31'd0, lnk_own}, {31'd0, !rel});
  endtask

  task automatic sys_pulse();
    @(negedge clk); sys_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 sys reset rst", {31'd0, drst_n}, 32'd0);
    check("R1 sys reset prog", {31'd0, prog_n}, 32'd0);
    check("R1 sys reset own", {31'd0, lnk_own}, 32'd1);
    check("R1 sys reset err", {31'd0, err}, 32'd0);
    sys_rst_n = 1'b1;
  endtask

  task automatic wait_ready(input string tg);
    for (int i = 0; i < 30 && !lnk_ready; i++) @(negedge clk);
    check({tg, " R3 ready"}, {31'd0, lnk_ready}, 32'd1);
  endtask

  // {byte, expected release}
  localparam logic [8:0] VEC [10] = '{
    {8'hAA,1'b0}, {8'h0D,1'b0}, {8'h0E,1'b0}, {8'hDE,1'b0}, {8'h55,1'b0},
    {8'h0D,1'b0}, {8'h0D,1'b0}, {8'h0E,1'b0}, {8'hDE,1'b0}, {8'hE0,1'b1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sys_rst_n = 1'b1; src_flash = 1'b0; lnk_valid = 1'b0;
    lnk_data = 8'h00; init = 1'b0; done = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset prog", {31'd0, prog_n}, 32'd0);
    check("R1 reset rst", {31'd0, drst_n}, 32'd0);
    check("R1 reset own", {31'd0, lnk_own}, 32'd1);
    check("R1 reset err", {31'd0, err}, 32'd0);
    check("R1 reset wr", {31'd0, wr_n}, 32'd1);
    rst_n = 1'b1;
    begin
      int w = 0;
      while (!prog_n && w < 50) begin @(negedge clk); w++; end
      check("R2 prog width>=4", {31'd0, (w >= 4)}, 32'd1);
    end
    repeat (10) @(negedge clk);
    check("R2 no ready before init", {31'd0, lnk_ready}, 32'd0);
    init = 1'b1;
    wait_ready("link");

    // R5 / R3 / R6 table: garbage, broken key, restart on 0x0D, full key
    for (int i = 0; i < 10; i++)
      send(VEC[i][8:1], VEC[i][0], $sformatf("R5 vec%0d", i));

    // R7: after release the link belongs to the FPGA
    check("R7 ready off", {31'd0, lnk_ready}, 32'd0);
    @(negedge clk); lnk_valid = 1'b1; lnk_data = 8'h77;
    repeat (3) begin
      @(negedge clk);
      check("R7 ignored byte", {31'd0, wr_n}, 32'd1);
    end
    lnk_valid = 1'b0;

    // R9: key alone releases
    sys_pulse();
    wait_ready("R9");
    send(8'h0D, 1'b0, "R9 k0");
    send(8'h0E, 1'b0, "R9 k1");
    send(8'hDE, 1'b0, "R9 k2");
    send(8'hE0, 1'b1, "R9 k3");

    // R8: DONE timeout
    done = 1'b0;
    sys_pulse();
    wait_ready("R8");
    send(8'h0D, 1'b0, "R8 k0");
    send(8'h0E, 1'b0, "R8 k1");
    send(8'hDE, 1'b0, "R8 k2");
    send(8'hE0, 1'b0, "R8 k3");
    repeat (20) @(negedge clk);
    check("R8 no early err", {31'd0, err}, 32'd0);
    repeat (60) @(negedge clk);
    check("R8 err set", {31'd0, err}, 32'd1);
    done = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 err sticky", {31'd0, err}, 32'd1);
    check("R8 rst held", {31'd0, drst_n}, 32'd0);
    sys_pulse();
    check("R8 err cleared", {31'd0, err}, 32'd0);

    // R4: flash mode
    done = 1'b0; src_flash = 1'b1;
    sys_pulse();
    ncap = 0; max_addr = 0; min_oe_run = 1000;
    for (int i = 0; i < 200 && ncap < 6; i++) begin
      @(negedge clk);
      if (lnk_ready) check("R7 no link in flash", 32'd1, 32'd0);
    end
    check("R4 byte count", ncap, 6);
    check("R4 b0", {24'd0, cap[0]}, 32'h34);
    check("R4 b1", {24'd0, cap[1]}, 32'h12);
    check("R4 b2", {24'd0, cap[2]}, 32'h0D);
    check("R4 b3", {24'd0, cap[3]}, 32'h0E);
    check("R4 b4", {24'd0, cap[4]}, 32'hDE);
    check("R4 b5", {24'd0, cap[5]}, 32'hE0);
    check("R4 max addr", max_addr, 2);
    check("R4 oe run>=4", {31'd0, (min_oe_run >= 4)}, 32'd1);
    check("R6 flash held w/o done", {31'd0, drst_n}, 32'd0);
    done = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 flash release", {31'd0, drst_n}, 32'd1);
    check("R7 flash own", {31'd0, lnk_own}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule